// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a synchronous two-port byte memory that two agents share. Each side has its own address, active-low chip enable, read/write select, active-low output enable, write data, registered read data, an active-low busy input and an active-low interrupt output. Both sides reach every location in the same clock cycle. When both sides write one location in the same cycle, the left side's byte is the one that is stored.

The two highest addresses also serve as a doorbell between the two agents. The left agent signals the right agent by writing the top address (DEPTH-1). The right agent signals the left agent by writing the address just below it (DEPTH-2). An agent acknowledges a signal by reading its own mailbox address, which raises its interrupt line again. These locations still hold the byte that was written, so one access carries a message and raises the doorbell. Each busy input holds off flag changes that its own side would cause. A reset places both interrupt lines in the released state.

The default configuration has a 10-bit address, so DEPTH is 1024, the left mailbox is 0x3FE and the right mailbox is 0x3FF. With `ADDR_W = 13` the memory is 8192 bytes and the mailboxes move to 0x1FFE and 0x1FFF.

Top module: `dpmb_top`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it goes low, both `l_int_n` and `r_int_n` are 1 and both read data outputs are 0x00.
- R2: A side performs a write when ce_n=0 and rw_n=0, and the byte is stored at that clock edge. A side performs a read when ce_n=0, rw_n=1 and oe_n=0. The stored byte appears on that side's rdata after the same edge. In any cycle without a read, rdata keeps its value.
- R3: A left write to address DEPTH-1 with `l_busy_n`=1 drives `r_int_n` to 0 from the next clock edge.
- R4: A right read of address DEPTH-1 with `r_busy_n`=1 returns `r_int_n` to 1 from the next clock edge.
- R5: A right write to address DEPTH-2 with `r_busy_n`=1 drives `l_int_n` to 0 from the next clock edge.
- R6: A left read of address DEPTH-2 with `l_busy_n`=1 returns `l_int_n` to 1 from the next clock edge.
- R7: A mailbox write has no effect on the flag while the writer's busy_n is 0. A mailbox read has no effect on the flag while the reader's busy_n is 0. The memory access itself still happens. Without a set or a clear, the interrupt outputs keep their value.
- R8: If a set and a clear of the same flag occur in the same cycle, the flag ends up set (interrupt output 0).
- R9: Mailbox addresses store data like ordinary memory. A read that happens in the same cycle as a write to the same address returns the byte stored before that write.
- R10: When both sides write the same address in one cycle, the left byte is stored.
- R11: A read attempt with oe_n=1 neither clears a flag nor changes rdata. A side that writes its own mailbox address changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| l_addr | input | ADDR_W | Left address |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_n | input | 1 | Left busy, active low; when low it blocks flag changes made by the left side |
| l_int_n | output | 1 | Left interrupt, active low |
| r_addr | input | ADDR_W | Right address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_n | input | 1 | Right busy, active low; when low it blocks flag changes made by the right side |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The state that matters here is the two flag registers and the stored bytes. A wrong flag shows on the interrupt pin one edge after the mailbox access that caused it, and it stays wrong until the next valid set or clear, so every check samples the pin in the cycle that follows each access. A stored byte that is wrong, or a byte lost in a write collision, stays hidden until the next read of that address and then appears on rdata one edge after the read. For that reason every write in the sequence is later read back from the other side. A busy gate that does not work, or a wrong set-over-clear priority, shows as an interrupt pin that changes, or fails to hold, in exactly that one cycle.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Mailbox that raises the given side's interrupt: the top address belongs
  // to the right side, the one below it to the left side.
  function automatic int unsigned mbox_addr(int unsigned aw, side_e side);
    int unsigned top;
    top = (32'd1 << aw) - 32'd1;
    return (side == SIDE_R) ? top : top - 32'd1;
  endfunction

  // Next state of an active-low flag; a set has priority over a clear.
  function automatic logic flag_next_n(logic cur_n, logic set, logic clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur_n;
  endfunction

endpackage

// File: rtl/dpmb_port_decode.sv
module dpmb_port_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OWN_MB = '1,
  parameter logic [ADDR_W-1:0] PEER_MB = '0
) (
  input  logic              ce_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic              rd_en,
  output logic              peer_mb_wr,
  output logic              own_mb_rd
);
  always_comb begin
    wr_en      = !ce_n && !rw_n;
    rd_en      = !ce_n && rw_n && !oe_n;
    peer_mb_wr = wr_en && (addr == PEER_MB);
    own_mb_rd  = rd_en && (addr == OWN_MB);
  end
endmodule

// File: rtl/dpmb_mem_array.sv
module dpmb_mem_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_we,
  input  logic              l_re,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_we,
  input  logic              r_re,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The right write comes first so that the left write overrides it on a collision.
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
  end

  // Registered reads return the contents from before this edge's writes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_re) l_rdata <= mem[l_addr];
      if (r_re) r_rdata <= mem[r_addr];
    end
  end
endmodule

// File: rtl/dpmb_irq_flag.sv
module dpmb_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic set_busy_n,
  input  logic clr_req,
  input  logic clr_busy_n,
  output logic set_evt,
  output logic clr_evt,
  output logic int_n
);
  import dpmb_pkg::*;

  assign set_evt = set_req && set_busy_n;
  assign clr_evt = clr_req && clr_busy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) int_n <= 1'b1;
    else        int_n <= flag_next_n(int_n, set_evt, clr_evt);
  end
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_ce_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_n,
  output logic              l_int_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_ce_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_n,
  output logic              r_int_n
);
  import dpmb_pkg::*;

  localparam logic [ADDR_W-1:0] MB_L = ADDR_W'(mbox_addr(ADDR_W, SIDE_L));
  localparam logic [ADDR_W-1:0] MB_R = ADDR_W'(mbox_addr(ADDR_W, SIDE_R));

  // Decoded events, brought out by name for the checker.
  logic l_we, l_re, l_mb_wr, l_mb_rd;
  logic r_we, r_re, r_mb_wr, r_mb_rd;
  logic set_l_evt, clr_l_evt, set_r_evt, clr_r_evt;

  dpmb_port_decode #(.ADDR_W(ADDR_W), .OWN_MB(MB_L), .PEER_MB(MB_R)) u_dec_l (
    .ce_n(l_ce_n), .rw_n(l_rw_n), .oe_n(l_oe_n), .addr(l_addr),
    .wr_en(l_we), .rd_en(l_re), .peer_mb_wr(l_mb_wr), .own_mb_rd(l_mb_rd)
  );

  dpmb_port_decode #(.ADDR_W(ADDR_W), .OWN_MB(MB_R), .PEER_MB(MB_L)) u_dec_r (
    .ce_n(r_ce_n), .rw_n(r_rw_n), .oe_n(r_oe_n), .addr(r_addr),
    .wr_en(r_we), .rd_en(r_re), .peer_mb_wr(r_mb_wr), .own_mb_rd(r_mb_rd)
  );

  dpmb_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .l_we(l_we), .l_re(l_re), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_we(r_we), .r_re(r_re), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // The right side writes this flag and the left side reads it back.
  dpmb_irq_flag u_flag_l (
    .clk(clk), .rst_n(rst_n),
    .set_req(r_mb_wr), .set_busy_n(r_busy_n),
    .clr_req(l_mb_rd), .clr_busy_n(l_busy_n),
    .set_evt(set_l_evt), .clr_evt(clr_l_evt), .int_n(l_int_n)
  );

  // The left side writes this flag and the right side reads it back.
  dpmb_irq_flag u_flag_r (
    .clk(clk), .rst_n(rst_n),
    .set_req(l_mb_wr), .set_busy_n(l_busy_n),
    .clr_req(r_mb_rd), .clr_busy_n(r_busy_n),
    .set_evt(set_r_evt), .clr_evt(clr_r_evt), .int_n(r_int_n)
  );
endmodule

// File: rtl/dpmb_checker.sv
module dpmb_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_re,
  input logic              r_re,
  input logic              l_mb_wr,
  input logic              r_mb_wr,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              set_l_evt,
  input logic              clr_l_evt,
  input logic              set_r_evt,
  input logic              clr_r_evt,
  input logic              l_int_n,
  input logic              r_int_n,
  input logic [DATA_W-1:0] l_rdata,
  input logic [DATA_W-1:0] r_rdata
);
  a_r3_set_right: assert property (@(posedge clk) disable iff (!rst_n)
    set_r_evt |=> !r_int_n);
  a_r4_clear_right: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r_evt && !set_r_evt) |=> r_int_n);
  a_r5_set_left: assert property (@(posedge clk) disable iff (!rst_n)
    set_l_evt |=> !l_int_n);
  a_r6_clear_left: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l_evt && !set_l_evt) |=> l_int_n);
  a_r7_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r_evt && !clr_r_evt) |=> $stable(r_int_n));
  a_r7_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_l_evt && !clr_l_evt) |=> $stable(l_int_n));
  a_r7_busy_blocks_right: assert property (@(posedge clk) disable iff (!rst_n)
    (l_mb_wr && !l_busy_n && !clr_r_evt) |=> $stable(r_int_n));
  a_r7_busy_blocks_left: assert property (@(posedge clk) disable iff (!rst_n)
    (r_mb_wr && !r_busy_n && !clr_l_evt) |=> $stable(l_int_n));
  a_r8_set_wins_right: assert property (@(posedge clk) disable iff (!rst_n)
    (set_r_evt && clr_r_evt) |=> !r_int_n);
  a_r2_hold_left_data: assert property (@(posedge clk) disable iff (!rst_n)
    !l_re |=> $stable(l_rdata));
  a_r2_hold_right_data: assert property (@(posedge clk) disable iff (!rst_n)
    !r_re |=> $stable(r_rdata));
endmodule

bind dpmb_top dpmb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_re(l_re), .r_re(r_re),
  .l_mb_wr(l_mb_wr), .r_mb_wr(r_mb_wr), .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .set_l_evt(set_l_evt), .clr_l_evt(clr_l_evt), .set_r_evt(set_r_evt), .clr_r_evt(clr_r_evt),
  .l_int_n(l_int_n), .r_int_n(r_int_n), .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/dpmb_top_bench.sv
module dpmb_top_bench;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int DW = 8;

  // Access codes packed as {ce_n, rw_n, oe_n}.
  localparam logic [2:0] C_IDLE  = 3'b111;
  localparam logic [2:0] C_WR    = 3'b001;
  localparam logic [2:0] C_RD    = 3'b010;
  localparam logic [2:0] C_RDNOE = 3'b011;

  typedef struct packed {
    logic [2:0]    lc;
    logic [AW-1:0] la;
    logic [DW-1:0] lw;
    logic          lb;
    logic [2:0]    rc;
    logic [AW-1:0] ra;
    logic [DW-1:0] rw;
    logic          rb;
    logic          el;
    logic          er;
    logic [DW-1:0] erl;
    logic [DW-1:0] err;
  } vec_t;

  // Mailboxes: left 0x3FE, right 0x3FF.
  localparam vec_t VECS [16] = '{
    '{C_WR,   10'h010, 8'hA5, 1'b1, C_WR,    10'h020, 8'h3C, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00}, // R2 writes
    '{C_RD,   10'h020, 8'h00, 1'b1, C_RD,    10'h010, 8'h00, 1'b1, 1'b1, 1'b1, 8'h3C, 8'hA5}, // R2 cross reads
    '{C_WR,   10'h3FF, 8'h77, 1'b1, C_IDLE,  10'h000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h3C, 8'hA5}, // R3 set right
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_RDNOE, 10'h3FF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h3C, 8'hA5}, // R11 oe_n high
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_RD,    10'h3FF, 8'h00, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h77}, // R7 busy blocks clear
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_RD,    10'h3FF, 8'h00, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h77}, // R4 clear right
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_WR,    10'h3FE, 8'h11, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h77}, // R7 busy blocks set
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_WR,    10'h3FE, 8'h22, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h77}, // R5 set left
    '{C_RD,   10'h3FE, 8'h00, 1'b1, C_WR,    10'h3FE, 8'h33, 1'b1, 1'b0, 1'b1, 8'h22, 8'h77}, // R8 set wins, R9 old data
    '{C_RD,   10'h3FE, 8'h00, 1'b1, C_IDLE,  10'h000, 8'h00, 1'b1, 1'b1, 1'b1, 8'h33, 8'h77}, // R6 clear left
    '{C_WR,   10'h040, 8'hAA, 1'b1, C_WR,    10'h040, 8'hBB, 1'b1, 1'b1, 1'b1, 8'h33, 8'h77}, // R10 collision
    '{C_RD,   10'h040, 8'h00, 1'b1, C_RD,    10'h040, 8'h00, 1'b1, 1'b1, 1'b1, 8'hAA, 8'hAA}, // R10 left kept
    '{C_WR,   10'h3FF, 8'h55, 1'b0, C_IDLE,  10'h000, 8'h00, 1'b1, 1'b1, 1'b1, 8'hAA, 8'hAA}, // R7 left busy
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_RD,    10'h3FF, 8'h00, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55}, // R9 mailbox data
    '{C_WR,   10'h3FE, 8'h99, 1'b1, C_IDLE,  10'h000, 8'h00, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55}, // R11 own mailbox
    '{C_IDLE, 10'h000, 8'h00, 1'b1, C_RD,    10'h3FE, 8'h00, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h99}  // R9 read by right
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_ce_n, l_rw_n, l_oe_n, r_ce_n, r_rw_n, r_oe_n;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_busy_n, r_busy_n, l_int_n, r_int_n;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dpmb_top #(.ADDR_W(AW), .DATA_W(DW)) u_dpmb_top (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_n(l_busy_n), .l_int_n(l_int_n),
    .r_addr(r_addr), .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_n(r_busy_n), .r_int_n(r_int_n)
  );

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [2:0] lc, logic [AW-1:0] la, logic [DW-1:0] lw, logic lb,
                       logic [2:0] rc, logic [AW-1:0] ra, logic [DW-1:0] rw, logic rb);
    {l_ce_n, l_rw_n, l_oe_n} = lc;
    l_addr = la; l_wdata = lw; l_busy_n = lb;
    {r_ce_n, r_rw_n, r_oe_n} = rc;
    r_addr = ra; r_wdata = rw; r_busy_n = rb;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    drive(C_IDLE, '0, '0, 1'b1, C_IDLE, '0, '0, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 l_int_n", {7'd0, l_int_n}, 8'd1);
    check("R1 r_int_n", {7'd0, r_int_n}, 8'd1);
    check("R1 l_rdata", l_rdata, 8'h00);
    check("R1 r_rdata", r_rdata, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      drive(VECS[i].lc, VECS[i].la, VECS[i].lw, VECS[i].lb,
            VECS[i].rc, VECS[i].ra, VECS[i].rw, VECS[i].rb);
      @(negedge clk);
      check($sformatf("vec%0d l_int_n", i), {7'd0, l_int_n}, {7'd0, VECS[i].el});
      check($sformatf("vec%0d r_int_n", i), {7'd0, r_int_n}, {7'd0, VECS[i].er});
      check($sformatf("vec%0d l_rdata", i), l_rdata, VECS[i].erl);
      check($sformatf("vec%0d r_rdata", i), r_rdata, VECS[i].err);
    end

    // R3 and R5 together: both flags set in one cycle
    drive(C_WR, 10'h3FF, 8'h01, 1'b1, C_WR, 10'h3FE, 8'h02, 1'b1);
    @(negedge clk);
    check("R3 both set r_int_n", {7'd0, r_int_n}, 8'd0);
    check("R5 both set l_int_n", {7'd0, l_int_n}, 8'd0);

    // R2: idle cycle holds read data and flags
    drive(C_IDLE, '0, '0, 1'b1, C_IDLE, '0, '0, 1'b1);
    @(negedge clk);
    check("R2 hold l_rdata", l_rdata, 8'hAA);
    check("R7 hold r_int_n", {7'd0, r_int_n}, 8'd0);

    // R1: reset while the flags are set
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset l_int_n", {7'd0, l_int_n}, 8'd1);
    check("R1 reset r_int_n", {7'd0, r_int_n}, 8'd1);
    check("R1 reset l_rdata", l_rdata, 8'h00);
    check("R1 reset r_rdata", r_rdata, 8'h00);
    rst_n = 1'b1;

    // R9: the mailbox kept the byte through reset
    drive(C_IDLE, '0, '0, 1'b1, C_RD, 10'h3FF, '0, 1'b1);
    @(negedge clk);
    check("R9 mailbox after reset", r_rdata, 8'h01);

    summary();
  end
endmodule